// File: doc/BRIEF.md
# Input Change-of-State Detector

This block watches four slowly changing, asynchronous input pins and records every level change that lasts long enough to be genuine. The pins are brought into the clock domain through a flop synchronizer. They are then looked at only on a coarse sampling strobe, one clock in every 96. With a 3.6864 MHz clock this gives a sampling rate of 38.4 kHz, about 26 µs per sample. A new level counts only after two strobes in a row have seen it. As a result, a pulse shorter than one sample period is never reported, and a pulse longer than two sample periods always is.

Each accepted change, rising or falling, sets a sticky flag for its input. A CPU reads a change register that holds the four flags together with the four filtered levels. That read clears the flags. An interrupt request stays high while any flag whose enable bit is set remains pending. A separate plain port read returns the synchronized levels of all seven input pins, with a constant 1 in the top bit.

Top module: `ipchg_detector`

## Requirements
- R1: A sampling strobe occurs once every STROBE_DIV clocks (default 96). Accepted changes therefore take effect only on clock edges spaced a whole multiple of STROBE_DIV apart.
- R2: A new level on a watched input is accepted only when two consecutive strobes both see it. A pulse lasting less than one strobe period is never accepted. A pulse lasting three or more strobe periods is always accepted.
- R3: An accepted change in either direction on watched input k (pins 0 to 3) sets delta flag k. The flag stays set until the change register is read. Changes on pins 4 to 6 set no flag.
- R4: The change register `chg_data_o` carries delta flag k in bit 4+k and the filtered level of input k in bit k. A clock edge with `chg_rd_i` high clears all flags, except those covered by R5.
- R5: If a change on input k is accepted on the same clock edge as a clearing read, delta flag k is set after that edge.
- R6: `irq_o` is high exactly when some delta flag k is set and `irq_mask_i[k]` is 1.
- R7: `port_data_o` returns the synchronized levels of all seven pins, with a High pin reading 1 in bit n for pin n, and bit 7 always 1.
- R8: After reset, no delta flag is pending, `irq_o` is low, and the filtered levels equal the pin levels that were held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 3.6864 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 7 | Asynchronous input pins; pins 0 to 3 are watched for changes |
| irq_mask_i | input | 4 | Per-input interrupt enable |
| chg_rd_i | input | 1 | Change-register read strobe; clears the delta flags on the edge |
| chg_data_o | output | 8 | Delta flags (bits 7:4) and filtered levels (bits 3:0) |
| port_data_o | output | 8 | Constant 1 in bit 7, synchronized pin levels in bits 6:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The clearing read and the acceptance of a new change can land on the same clock edge. If the clear wins, that change is lost. The bench first finds the exact edge on which one change is accepted. It then toggles a second input just after a later strobe and schedules the read for the edge exactly two strobe periods later. The result is judged by two checks. One cycle before that edge, the second flag must still be clear. After the edge, the second flag must be set while every older flag is gone.

// File: rtl/ipchg_pkg.sv
package ipchg_pkg;
  localparam int unsigned IPCHG_MON_W  = 4;
  localparam int unsigned IPCHG_PIN_W  = 7;
  localparam int unsigned IPCHG_DIV    = 96;
  localparam int unsigned IPCHG_STAGES = 2;

  function automatic int unsigned cw_of(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ipchg_rst_sync.sv
module ipchg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] rs_q;
  logic [1:0] rs_d;

  always_comb begin
    rs_d = {rs_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= rs_d;
  end

  assign rst_core_n = rs_q[1];
endmodule

// File: rtl/ipchg_sync.sv
module ipchg_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb st_d[s] = d_i;
    end else begin : g_next
      always_comb st_d[s] = st_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= '0;
      else        st_q[s] <= st_d[s];
    end
  end

  assign q_o = st_q[STAGES-1];

  assert_sync_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st_q[0] == $past(d_i)));
endmodule

// File: rtl/ipchg_strobe_gen.sv
module ipchg_strobe_gen #(
  parameter int unsigned DIV = 96
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe_o
);
  localparam int unsigned CW = ipchg_pkg::cw_of(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          hit;

  always_comb begin
    hit   = (cnt_q == LAST);
    cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe_o = hit;

  assert_strobe_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
  assert_strobe_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_strobe_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> (cnt_q == '0));
endmodule

// File: rtl/ipchg_filter.sv
module ipchg_filter #(
  parameter int unsigned N      = 4,
  parameter int unsigned SETTLE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic [N-1:0] sync_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] accept_o
);
  localparam int unsigned IW = ipchg_pkg::cw_of(SETTLE + 1);
  localparam logic [IW-1:0] READY_AT = IW'(SETTLE);

  logic [IW-1:0] init_q, init_d;
  logic [N-1:0]  samp_q, samp_d;
  logic [N-1:0]  filt_q, filt_d;
  logic [N-1:0]  acc;
  logic          ready;

  assign ready = (init_q == READY_AT);

  for (genvar k = 0; k < N; k++) begin : g_acc
    always_comb begin
      acc[k] = ready && strobe_i &&
               (sync_i[k] == samp_q[k]) && (sync_i[k] != filt_q[k]);
    end
  end

  always_comb begin
    init_d = ready ? init_q : init_q + 1'b1;
    samp_d = samp_q;
    filt_d = filt_q;
    if (!ready) begin
      samp_d = sync_i;
      filt_d = sync_i;
    end else if (strobe_i) begin
      samp_d = sync_i;
      filt_d = filt_q ^ acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      samp_q <= '0;
      filt_q <= '0;
    end else begin
      init_q <= init_d;
      samp_q <= samp_d;
      filt_q <= filt_d;
    end
  end

  assign level_o  = filt_q;
  assign accept_o = acc;

  assert_filt_hold_off_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !strobe_i) |=> $stable(filt_q));
  assert_single_sample_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && strobe_i && (sync_i != samp_q) && (sync_i == ~samp_q)) |=> $stable(filt_q));
  assert_accept_only_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (accept_o == '0));
  assert_accept_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o != '0) |-> strobe_i);
endmodule

// File: rtl/ipchg_delta.sv
module ipchg_delta #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] accept_i,
  input  logic         clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] delta_o,
  output logic         irq_o
);
  logic [N-1:0] delta_q;
  logic [N-1:0] delta_d;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_comb begin
      delta_d[k] = accept_i[k] | (delta_q[k] & ~clr_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delta_q <= '0;
    else        delta_q <= delta_d;
  end

  assign delta_o = delta_q;
  assign irq_o   = |(delta_q & mask_i);

  assert_delta_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((delta_q & ~$past(accept_i)) == '0));
  assert_clash_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (accept_i != '0)) |=> ((delta_q & $past(accept_i)) == $past(accept_i)));
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_q == '0) |-> !irq_o);
endmodule

// File: rtl/ipchg_detector.sv
module ipchg_detector #(
  parameter int unsigned PIN_W      = ipchg_pkg::IPCHG_PIN_W,
  parameter int unsigned MON_W      = ipchg_pkg::IPCHG_MON_W,
  parameter int unsigned STROBE_DIV = ipchg_pkg::IPCHG_DIV,
  parameter int unsigned SYNC_STG   = ipchg_pkg::IPCHG_STAGES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_W-1:0]   pin_i,
  input  logic [MON_W-1:0]   irq_mask_i,
  input  logic               chg_rd_i,
  output logic [2*MON_W-1:0] chg_data_o,
  output logic [PIN_W:0]     port_data_o,
  output logic               irq_o
);
  localparam int unsigned SETTLE = SYNC_STG + 1;

  logic             rst_core_n;
  logic [PIN_W-1:0] pin_sync;
  logic             strobe;
  logic [MON_W-1:0] level;
  logic [MON_W-1:0] accept;
  logic [MON_W-1:0] delta;

  ipchg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  ipchg_sync #(.W(PIN_W), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  ipchg_strobe_gen #(.DIV(STROBE_DIV)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .strobe_o (strobe)
  );

  ipchg_filter #(.N(MON_W), .SETTLE(SETTLE)) u_filter (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .strobe_i (strobe),
    .sync_i   (pin_sync[MON_W-1:0]),
    .level_o  (level),
    .accept_o (accept)
  );

  ipchg_delta #(.N(MON_W)) u_delta (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .accept_i (accept),
    .clr_i    (chg_rd_i),
    .mask_i   (irq_mask_i),
    .delta_o  (delta),
    .irq_o    (irq_o)
  );

  assign chg_data_o  = {delta, level};
  assign port_data_o = {1'b1, pin_sync};

  assert_port_top_one_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    port_data_o[PIN_W]);
  assert_reset_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> !irq_o);
endmodule

// File: tb/ipchg_detector_tb.sv
module ipchg_detector_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic [6:0] pin;
  logic [3:0] mask;
  logic       rd;
  logic [7:0] chg;
  logic [7:0] port;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ipchg_detector dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .irq_mask_i  (mask),
    .chg_rd_i    (rd),
    .chg_data_o  (chg),
    .port_data_o (port),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // {pins[14:8], mask[7:4], expected delta[3:0]}
  localparam logic [14:0] VEC [6] = '{
    {7'h5B, 4'hF, 4'h1},
    {7'h53, 4'h0, 4'h8},
    {7'h2C, 4'h4, 4'hF},
    {7'h7C, 4'hF, 4'h0},
    {7'h2A, 4'h8, 4'h6},
    {7'h2A, 4'hF, 4'h0}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_read();
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [6:0] cur;
    int k;
    rst_n = 1'b0;
    pin   = 7'h5A;
    mask  = 4'hF;
    rd    = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(20);
    // R8: reset state
    check("R8 reset chg", chg, 8'h0A);
    check("R8 reset irq", {7'b0, irq}, 8'h00);
    check("R7 reset port", port, 8'hDA);

    cur = 7'h5A;
    for (int i = 0; i < 6; i++) begin
      logic [6:0] vp;
      logic [3:0] vm;
      logic [3:0] vd;
      vp = VEC[i][14:8];
      vm = VEC[i][7:4];
      vd = VEC[i][3:0];
      mask = vm;
      pin  = vp;
      cyc(300);
      check($sformatf("R3/R4 vec%0d chg", i), chg, {vd, vp[3:0]});
      check($sformatf("R7 vec%0d port", i), port, {1'b1, vp});
      check($sformatf("R6 vec%0d irq", i), {7'b0, irq}, {7'b0, |(vd & vm)});
      clear_read();
      check($sformatf("R4 vec%0d cleared", i), chg, {4'h0, vp[3:0]});
      check($sformatf("R6 vec%0d irq after read", i), {7'b0, irq}, 8'h00);
      cur = vp;
    end

    // R2: short glitch of under one strobe period is ignored
    mask = 4'hF;
    pin  = cur ^ 7'h01;
    cyc(50);
    pin  = cur;
    cyc(300);
    check("R2 short glitch ignored", chg, {4'h0, cur[3:0]});
    check("R2 short glitch no irq", {7'b0, irq}, 8'h00);

    // R2/R3: long pulse is accepted both ways, flag sticky
    pin = cur ^ 7'h01;
    cyc(300);
    check("R2 long pulse level", chg, {4'h1, cur[3:0] ^ 4'h1});
    pin = cur;
    cyc(300);
    check("R3 sticky after return", chg, {4'h1, cur[3:0]});
    clear_read();

    // R1/R5: locate an accept edge, then clash a read with the next accept
    mask = 4'h0;
    pin  = cur ^ 7'h01;
    k = 0;
    while (chg[4] == 1'b0 && k < 400) begin
      cyc(1);
      k++;
    end
    check("R1 first accept seen", {7'b0, chg[4]}, 8'h01);
    clear_read();              // clears on edge E+1
    pin = cur ^ 7'h03;         // input 1 changes after E+1
    cyc(190);                  // negedge after edge E+191
    check("R1 not accepted early", chg[7:4], 4'h0);
    rd = 1'b1;
    cyc(1);                    // edge E+192: accept and clear together
    rd = 1'b0;
    check("R5 clash keeps new flag", chg, {4'h2, cur[3:0] ^ 4'h3});
    check("R6 masked clash irq", {7'b0, irq}, 8'h00);
    mask = 4'h2;
    cyc(1);
    check("R6 unmask raises irq", {7'b0, irq}, 8'h01);

    // R8: reset with a pending flag
    pin   = 7'h11;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(20);
    mask = 4'hF;
    cyc(1);
    check("R8 reset clears flag", chg, 8'h01);
    check("R8 reset irq low", {7'b0, irq}, 8'h00);
    check("R7 port after reset", port, 8'h91);

    done = 1;
    finish_run();
  end
endmodule